// File: doc/BRIEF.md
# Programmable Peripheral Clock Divider

This block derives a peripheral clock from the system clock by an integer ratio that software picks through a small control register. A 7-bit field N selects a ratio of N+1, from 1 to 128. A value of zero routes the system clock straight to the output. A new ratio can be written while the divider is running. The new ratio is held back until the current output period has finished, so no short high or low pulse reaches the output. A read-only ready flag is low for the whole changeover.

Writes are gated by an unlock level that an external key-sequence checker supplies. The output enable bit gates the clock. In the default configuration this bit is held at 1 and a write of 0 to it has no effect. A parameter selects a variant in which the bit can be written.

Top module: `pclk_divider`

## Requirements
- R1: With divisor field N (rd_data[6:0]) in 1..127, clk_out repeats with a period of N+1 system clocks.
- R2: With N = 0, clk_out follows clk: it is high while clk is high and low while clk is low.
- R3: After reset, rd_data reads 0x0000_8801 and clk_out divides by 2.
- R4: A write taken while ready (rd_data[11]) is 1 clears ready on the next cycle and loads the field from wr_data[6:0]. A divisor write made while ready is 0 is ignored.
- R5: The enable bit (rd_data[15]) resets to 1 and gates clk_out. With the default locked setting, a write of 0 to wr_data[15] leaves it at 1 and clk_out keeps running.
- R6: A write strobe while unlock is low changes nothing and starts no changeover.
- R7: Ready resets to 1 and stays at 1 while no write arrives.
- R8: A new divisor starts only at the end of a complete old output period, and every output pulse during a change has the old or the new length. Ready returns to 1 one system clock after the first new period starts.
- R9: The high phase of each period lasts floor((N+1)/2) system clocks and the low phase lasts the rest.
- R10: Bits of rd_data other than 15, 11 and 6:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 32 | Write data: bit 15 enable, bits 6:0 divisor |
| unlock | input | 1 | Level from the key-sequence checker; writes need it high |
| rd_data | output | 32 | Status and control readback |
| clk_out | output | 1 | Divided peripheral clock |

## Verification
The checker assumes that wr_en is a single-cycle strobe and that unlock is a steady level that is valid during the strobe cycle. The bench meets this by driving every input just after a rising edge. It holds each input for exactly one cycle and drops unlock again after every strobe. The bench sweeps the divisor through a dense low range and the maximum. It also covers writes made during a changeover, writes made while unlock is low, and a long-to-short ratio change, where it watches every pulse width.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;
    localparam int ENA_BIT = 15;
    localparam int RDY_BIT = 11;
    localparam int REG_W   = 32;
endpackage

// File: rtl/pclk_div_core.sv
module pclk_div_core #(
    parameter int DIV_W   = 7,
    parameter int DIV_RST = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             phase_o,
    output logic             bypass_o,
    output logic             ready_o,
    output logic [DIV_W-1:0] req_o
);
    localparam logic [DIV_W-1:0] RST_V = DIV_W'(DIV_RST);

    typedef struct packed {
        logic [DIV_W-1:0] cur;
        logic [DIV_W-1:0] req;
        logic [DIV_W-1:0] cnt;
        logic             pend;
        logic             loaded;
        logic             ready;
        logic             phase;
        logic             bypass;
    } core_st_t;

    core_st_t st_d, st_q;
    logic         wrap;
    logic [DIV_W:0] hi_len;

    always_comb begin
        st_d        = st_q;
        st_d.loaded = 1'b0;
        wrap        = (st_q.cnt == st_q.cur);
        hi_len      = ({1'b0, st_q.cur} + {{DIV_W{1'b0}}, 1'b1}) >> 1;
        if (st_q.pend && wrap) begin
            // old period complete: switch ratio, start a fresh high phase
            st_d.cur    = st_q.req;
            st_d.cnt    = '0;
            st_d.pend   = 1'b0;
            st_d.loaded = 1'b1;
            st_d.bypass = (st_q.req == '0);
            st_d.phase  = (st_q.req != '0);
        end else begin
            st_d.cnt   = wrap ? '0 : st_q.cnt + 1'b1;
            st_d.phase = ({1'b0, st_d.cnt} < hi_len);
        end
        if (st_q.loaded) st_d.ready = 1'b1;
        if (load_i) begin
            st_d.req   = div_i;
            st_d.pend  = 1'b1;
            st_d.ready = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cur    <= RST_V;
            st_q.req    <= RST_V;
            st_q.cnt    <= '0;
            st_q.pend   <= 1'b0;
            st_q.loaded <= 1'b0;
            st_q.ready  <= 1'b1;
            st_q.phase  <= (RST_V != '0);
            st_q.bypass <= (RST_V == '0);
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.phase;
    assign bypass_o = st_q.bypass;
    assign ready_o  = st_q.ready;
    assign req_o    = st_q.req;
endmodule

// File: rtl/pclk_div_gate.sv
module pclk_div_gate (
    input  logic clk_i,
    input  logic phase_i,
    input  logic bypass_i,
    input  logic en_i,
    output logic clk_o
);
    // bypass_i and phase_i change only at a rising edge, when both sides are high
    assign clk_o = en_i & (bypass_i ? clk_i : phase_i);
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider #(
    parameter int DIV_W     = 7,
    parameter int DIV_RST   = 1,
    parameter bit EN_LOCKED = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        unlock,
    output logic [31:0] rd_data,
    output logic        clk_out
);
    import pclk_div_pkg::*;

    typedef struct packed {
        logic en;
    } reg_st_t;

    reg_st_t reg_d, reg_q;
    logic             wr_ok;
    logic             accept;
    logic             en_nxt;
    logic             phase_w, bypass_w, ready_w;
    logic [DIV_W-1:0] req_w;

    assign wr_ok  = wr_en & unlock;
    assign accept = wr_ok & ready_w;

    generate
        if (EN_LOCKED) begin : g_en_locked
            assign en_nxt = reg_q.en;
        end else begin : g_en_free
            assign en_nxt = wr_ok ? wr_data[ENA_BIT] : reg_q.en;
        end
    endgenerate

    always_comb begin
        reg_d    = reg_q;
        reg_d.en = en_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q.en <= 1'b1;
        else        reg_q    <= reg_d;
    end

    pclk_div_core #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .div_i   (wr_data[DIV_W-1:0]),
        .phase_o (phase_w),
        .bypass_o(bypass_w),
        .ready_o (ready_w),
        .req_o   (req_w)
    );

    pclk_div_gate u_gate (
        .clk_i   (clk),
        .phase_i (phase_w),
        .bypass_i(bypass_w),
        .en_i    (reg_q.en),
        .clk_o   (clk_out)
    );

    always_comb begin
        rd_data                = '0;
        rd_data[ENA_BIT]       = reg_q.en;
        rd_data[RDY_BIT]       = ready_w;
        rd_data[DIV_W-1:0]     = req_w;
    end
endmodule

// File: rtl/pclk_div_chk.sv
module pclk_div_chk #(
    parameter bit EN_LOCKED = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        unlock,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data
);
    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unlock && rd_data[11]) |=> (!rd_data[11] && rd_data[6:0] == $past(wr_data[6:0])));

    p_busy_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unlock && !rd_data[11]) |=> $stable(rd_data[6:0]));

    p_locked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlock) |=> ($stable(rd_data[6:0]) && $stable(rd_data[15])));

    p_ready_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && rd_data[11]) |=> rd_data[11]);

    generate
        if (EN_LOCKED) begin : g_en_chk
            p_en_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && unlock && !wr_data[15]) |=> rd_data[15]);
        end
    endgenerate
endmodule

bind pclk_divider pclk_div_chk #(.EN_LOCKED(EN_LOCKED)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .unlock (unlock),
    .wr_data(wr_data),
    .rd_data(rd_data)
);

// File: tb/pclk_divider_tb.sv
module pclk_divider_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        unlock = 1'b0;
    logic [31:0] rd_data;
    logic        clk_out;

    int n_run = 0;
    int n_fail = 0;
    logic s_out = 1'b0, h1 = 1'b0, h2 = 1'b0, s_rdy = 1'b0;

    pclk_divider u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .unlock(unlock), .rd_data(rd_data), .clk_out(clk_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        h2 = h1;
        h1 = s_out;
        s_out = clk_out;
        s_rdy = rd_data[11];
    endtask

    task automatic do_write(input logic [31:0] d, input logic unl);
        wr_data = d;
        unlock  = unl;
        wr_en   = 1'b1;
        tick();
        wr_en   = 1'b0;
        unlock  = 1'b0;
    endtask

    // waits for ready; optionally checks it rose one cycle after a new-period start (R8)
    task automatic wait_ready(input bit chk_edge);
        for (int i = 0; i < 400; i++) begin
            if (s_rdy) break;
            tick();
            if (s_rdy && chk_edge)
                chk(h1 == 1'b1 && h2 == 1'b0, "R8 ready one clock after new period", {h2, h1}, 2'b01);
        end
        chk(s_rdy == 1'b1, "R7 ready returns", s_rdy, 1);
    endtask

    task automatic measure(input int n);
        int hi, lo, exp_hi;
        exp_hi = (n + 1) / 2;
        for (int rep = 0; rep < 2; rep++) begin
            for (int i = 0; i < 400; i++) begin
                tick();
                if (h1 == 1'b0 && s_out == 1'b1) break;
            end
            hi = 1;
            lo = 0;
            for (int i = 0; i < 400; i++) begin
                tick();
                if (s_out == 1'b1 && lo > 0) break;
                if (s_out) hi++; else lo++;
            end
            chk(hi + lo == n + 1, "R1 period", hi + lo, n + 1);
            chk(hi == exp_hi, "R9 high phase", hi, exp_hi);
        end
    endtask

    task automatic measure_bypass();
        bit ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            if (clk_out !== 1'b1) ok = 1'b0;
            @(negedge clk); #1;
            if (clk_out !== 1'b0) ok = 1'b0;
        end
        chk(ok, "R2 divide-by-1 follows clk", ok, 1);
        tick();
    endtask

    task automatic set_div(input int n, input int old_n);
        do_write(32'h0000_8000 | 32'(n), 1'b1);
        chk(s_rdy == 1'b0, "R4 ready drops", s_rdy, 0);
        wait_ready(n != 0 && old_n != 0);
        chk(rd_data[6:0] == 7'(n), "R1 readback", rd_data[6:0], n);
        chk((rd_data & ~32'h0000_887F) == 0, "R10 reserved zero", rd_data, rd_data & 32'h887F);
        if (n == 0) measure_bypass();
        else measure(n);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int prev;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        chk(rd_data == 32'h0000_8801, "R3 reset readback", rd_data, 32'h8801);
        chk(s_rdy == 1'b1, "R7 ready at reset", s_rdy, 1);
        repeat (5) begin
            tick();
            chk(!rd_data[11] == 1'b0, "R7 ready stays idle", rd_data[11], 1);
        end
        measure(1);

        prev = 1;
        for (int n = 0; n <= 20; n++) begin
            set_div(n, prev);
            prev = n;
        end
        set_div(127, prev);
        set_div(3, 127);

        // R6: locked write
        do_write(32'h0000_0007, 1'b0);
        chk(s_rdy == 1'b1, "R6 no changeover when locked", s_rdy, 1);
        chk(rd_data[6:0] == 7'd3, "R6 divisor unchanged", rd_data[6:0], 3);
        measure(3);

        // R4: write while busy is ignored
        do_write(32'h0000_8005, 1'b1);
        chk(s_rdy == 1'b0, "R4 busy after write", s_rdy, 0);
        do_write(32'h0000_8009, 1'b1);
        wait_ready(1'b0);
        chk(rd_data[6:0] == 7'd5, "R4 busy write ignored", rd_data[6:0], 5);
        measure(5);

        // R5: enable write of 0 has no effect
        do_write(32'h0000_0004, 1'b1);
        chk(rd_data[15] == 1'b1, "R5 enable held", rd_data[15], 1);
        wait_ready(1'b1);
        measure(4);

        // R8: change from 20 to 3, every pulse must be an old or new length
        set_div(20, 4);
        for (int k = 0; k < 7; k++) tick();
        begin
            int run, nruns;
            bit ok;
            ok = 1'b1; run = 0; nruns = 0;
            do_write(32'h0000_8003, 1'b1);
            for (int i = 0; i < 80; i++) begin
                tick();
                if (s_out == h1) run++;
                else begin
                    if (nruns > 0) begin
                        if (h1 && !(run == 10 || run == 2)) ok = 1'b0;
                        if (!h1 && !(run == 11 || run == 2)) ok = 1'b0;
                    end
                    nruns++;
                    run = 1;
                end
            end
            chk(ok, "R8 no runt pulse on change", ok, 1);
            chk(s_rdy == 1'b1, "R8 change completed", s_rdy, 1);
        end
        measure(3);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule